// File: doc/BRIEF.md
# Word and Bit Clock Lock Monitor

This block runs on the master clock of an audio bit-stream engine. It keeps two free-running boundary counters, one for the audio word period and one for the serial bit period. It locks them to an external word clock and an external bit clock that arrive with no known phase relation to the master clock. Both inputs pass through a two-flop synchronizer before their edges are detected. After a hardware reset, a soft reset or a sync error, the word counter is re-aligned to the next rising edge of the word clock. The bit counter is re-aligned to the next falling edge of the bit clock.

Once aligned, every later edge is compared with the boundary the counter predicts. An edge up to two master clocks early or one master clock late is accepted. Any edge outside that window is a sync error, and so is an expected edge that never arrives. An error drops the lock indicator in the next cycle, sets a sticky resynchronization request and re-arms both counters for alignment. Lock is granted again only after two consecutive good word periods.

The word period is 1024 or 1280 master clocks, chosen by a strap. The bit period is the word period divided by 128 or by 64, chosen by a rate select. The block also produces one-cycle strobes at the internal word and bit boundaries.

Top module: `lockmon`

## Requirements
- R1: While `rst_n` is low, `lock`, `resync_req`, `word_stb` and `bit_stb` are all low, including when reset is applied during lock.
- R2: Once locked, `word_stb` pulses exactly once every 1024 master clocks when `ratio_sel`=0 and once every 1280 when `ratio_sel`=1.
- R3: Once locked, `bit_stb` pulses once every word period divided by 128 when `rate_hi`=1 and divided by 64 when `rate_hi`=0, which gives 8, 16, 10 or 20 master clocks.
- R4: After alignment to the first word clock rising edge, `lock` rises only after two consecutive good word periods: it is low one and a half word periods after alignment and high three and a half word periods after it.
- R5: A word clock rising edge arriving up to 2 master clocks early or up to 1 master clock late causes no error, and `lock` stays high.
- R6: A word clock rising edge 3 or more master clocks early or 2 or more late pulses `word_err`, and `lock` falls in the next cycle.
- R7: A bit clock falling edge is judged against the same window of 2 early to 1 late: inside it nothing happens, outside it `bit_err` pulses and `lock` falls.
- R8: A missing word clock edge is an error: `word_err` pulses and `lock` falls.
- R9: Any sync error sets `resync_req`, which stays high until reset or soft reset. The block re-aligns on its own and relocks two good word periods later.
- R10: A one-cycle `soft_rst` drops `lock`, clears `resync_req` and re-arms alignment. Lock returns only after two new good word periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous one-cycle re-arm request |
| ratio_sel | input | 1 | Strap: 0 gives 1024 master clocks per word, 1 gives 1280 |
| rate_hi | input | 1 | 1 gives 128 bits per word, 0 gives 64 bits per word |
| wclk_in | input | 1 | External word clock, asynchronous |
| bclk_in | input | 1 | External bit clock, asynchronous |
| lock | output | 1 | Both clocks in sync |
| word_stb | output | 1 | One-cycle pulse at the internal word boundary |
| bit_stb | output | 1 | One-cycle pulse at the internal bit boundary |
| word_err | output | 1 | One-cycle pulse on a word clock sync error |
| bit_err | output | 1 | One-cycle pulse on a bit clock sync error |
| resync_req | output | 1 | Sticky flag set by any sync error |

## Verification
Clean clocks in all four ratio and rate combinations show that the two counters find the right period. A clean run also shows that lock waits for the second good word and not the first. Single word edges shifted by -3, -2, +1 and +2 master clocks probe both sides of the asymmetric window, so an off-by-one on either side shows up as a wrong lock value. The same four shifts applied to one bit clock edge confirm that the bit path is judged on its own. A silenced word clock, a soft reset and a reset during lock separate the missing-edge detector, the sticky request and the re-arm path from one another.

// File: rtl/lockmon_pkg.sv
package lockmon_pkg;

  // True when a counter value lies inside the acceptance window around
  // the predicted boundary (value 0): early side wraps to the period tail.
  function automatic logic in_window(input logic [31:0] cnt,
                                     input logic [31:0] per,
                                     input int unsigned early,
                                     input int unsigned late);
    return (cnt >= per - early) || (cnt <= late);
  endfunction

  // Bit period lookup: strap picks the word ratio, rate picks bits per word.
  function automatic logic [31:0] pick_bit_period(input logic ratio,
                                                  input logic fast,
                                                  input logic [31:0] lo_fast,
                                                  input logic [31:0] lo_slow,
                                                  input logic [31:0] hi_fast,
                                                  input logic [31:0] hi_slow);
    if (ratio) return fast ? hi_fast : hi_slow;
    return fast ? lo_fast : lo_slow;
  endfunction

endpackage

// File: rtl/lockmon_edge.sv
module lockmon_edge #(
  parameter bit RISING = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic edge_pulse
);
  logic [2:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[1:0], din};
  end

  generate
    if (RISING) begin : g_rise
      assign edge_pulse = sh[1] & ~sh[2];
    end else begin : g_fall
      assign edge_pulse = ~sh[1] & sh[2];
    end
  endgenerate
endmodule

// File: rtl/lockmon_track.sv
module lockmon_track #(
  parameter int CW    = 11,
  parameter int EARLY = 2,
  parameter int LATE  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rearm,
  input  logic [CW-1:0] period,
  input  logic          edge_in,
  output logic          tracking,
  output logic          boundary,
  output logic          err,
  output logic          good
);
  localparam logic [CW-1:0] EVAL_AT = CW'(LATE + 1);

  logic [CW-1:0] cnt;
  logic          got_edge;
  logic          primed;
  logic          win;
  logic          eval;
  logic          stray;
  logic          missing;

  assign win      = lockmon_pkg::in_window(32'(cnt), 32'(period), EARLY, LATE);
  assign eval     = tracking && (cnt == EVAL_AT);
  assign stray    = tracking && edge_in && !win;
  assign missing  = eval && primed && !got_edge;
  assign err      = stray || missing;
  assign good     = eval && primed && got_edge && !err;
  assign boundary = tracking && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tracking <= 1'b0;
      cnt      <= '0;
      got_edge <= 1'b0;
      primed   <= 1'b0;
    end else if (rearm) begin
      tracking <= 1'b0;
      cnt      <= '0;
      got_edge <= 1'b0;
      primed   <= 1'b0;
    end else if (!tracking) begin
      if (edge_in) begin
        tracking <= 1'b1;
        cnt      <= CW'(1);
        got_edge <= 1'b0;
        primed   <= 1'b0;
      end
    end else begin
      cnt <= (cnt == period - 1'b1) ? '0 : cnt + 1'b1;
      if (eval) begin
        got_edge <= 1'b0;
        primed   <= 1'b1;
      end else if (edge_in && win) begin
        got_edge <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lockmon.sv
module lockmon #(
  parameter int WORD_DIV_LO = 1024,
  parameter int WORD_DIV_HI = 1280,
  parameter int FAST_BITS   = 128,
  parameter int SLOW_BITS   = 64,
  parameter int WIN_EARLY   = 2,
  parameter int WIN_LATE    = 1,
  parameter int LOCK_GOOD   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic ratio_sel,
  input  logic rate_hi,
  input  logic wclk_in,
  input  logic bclk_in,
  output logic lock,
  output logic word_stb,
  output logic bit_stb,
  output logic word_err,
  output logic bit_err,
  output logic resync_req
);
  localparam int WCW     = $clog2(WORD_DIV_HI + 1);
  localparam int BP_LO_F = WORD_DIV_LO / FAST_BITS;
  localparam int BP_LO_S = WORD_DIV_LO / SLOW_BITS;
  localparam int BP_HI_F = WORD_DIV_HI / FAST_BITS;
  localparam int BP_HI_S = WORD_DIV_HI / SLOW_BITS;
  localparam int BCW     = $clog2(BP_HI_S + 1);
  localparam int GCW     = $clog2(LOCK_GOOD + 1);

  logic [WCW-1:0] wper;
  logic [BCW-1:0] bper;
  logic           w_edge, b_edge;
  logic           w_trk, b_trk;
  logic           w_err, b_err;
  logic           w_ok, b_ok;
  logic           any_err;
  logic           rearm;
  logic [GCW-1:0] good_cnt;

  assign wper = ratio_sel ? WCW'(WORD_DIV_HI) : WCW'(WORD_DIV_LO);
  assign bper = BCW'(lockmon_pkg::pick_bit_period(ratio_sel, rate_hi,
                     32'(BP_LO_F), 32'(BP_LO_S), 32'(BP_HI_F), 32'(BP_HI_S)));

  lockmon_edge #(.RISING(1'b1)) u_wsync (
    .clk(clk), .rst_n(rst_n), .din(wclk_in), .edge_pulse(w_edge));

  lockmon_edge #(.RISING(1'b0)) u_bsync (
    .clk(clk), .rst_n(rst_n), .din(bclk_in), .edge_pulse(b_edge));

  assign any_err = w_err | b_err;
  assign rearm   = soft_rst | any_err;

  lockmon_track #(.CW(WCW), .EARLY(WIN_EARLY), .LATE(WIN_LATE)) u_wtrk (
    .clk(clk), .rst_n(rst_n), .rearm(rearm), .period(wper), .edge_in(w_edge),
    .tracking(w_trk), .boundary(word_stb), .err(w_err), .good(w_ok));

  lockmon_track #(.CW(BCW), .EARLY(WIN_EARLY), .LATE(WIN_LATE)) u_btrk (
    .clk(clk), .rst_n(rst_n), .rearm(rearm), .period(bper), .edge_in(b_edge),
    .tracking(b_trk), .boundary(bit_stb), .err(b_err), .good(b_ok));

  assign word_err = w_err;
  assign bit_err  = b_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock       <= 1'b0;
      good_cnt   <= '0;
      resync_req <= 1'b0;
    end else if (soft_rst) begin
      lock       <= 1'b0;
      good_cnt   <= '0;
      resync_req <= 1'b0;
    end else if (any_err) begin
      lock       <= 1'b0;
      good_cnt   <= '0;
      resync_req <= 1'b1;
    end else if (w_ok) begin
      if (!b_trk) begin
        good_cnt <= '0;
      end else if (good_cnt != GCW'(LOCK_GOOD)) begin
        good_cnt <= good_cnt + 1'b1;
        if (good_cnt == GCW'(LOCK_GOOD - 1)) lock <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lockmon_chk.sv
module lockmon_chk #(
  parameter int WORD_DIV_LO = 1024,
  parameter int WORD_DIV_HI = 1280,
  parameter int FAST_BITS   = 128,
  parameter int SLOW_BITS   = 64
) (
  input logic clk,
  input logic rst_n,
  input logic soft_rst,
  input logic ratio_sel,
  input logic rate_hi,
  input logic lock,
  input logic word_stb,
  input logic bit_stb,
  input logic resync_req,
  input logic w_err,
  input logic b_err,
  input logic w_ok,
  input logic w_trk,
  input logic b_trk
);
  int unsigned wgap, bgap, wexp, bexp;

  assign wexp = ratio_sel ? WORD_DIV_HI : WORD_DIV_LO;
  assign bexp = wexp / (rate_hi ? FAST_BITS : SLOW_BITS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wgap <= 0;
      bgap <= 0;
    end else begin
      wgap <= word_stb ? 0 : ((wgap < 100000) ? wgap + 1 : wgap);
      bgap <= bit_stb  ? 0 : ((bgap < 100000) ? bgap + 1 : bgap);
    end
  end

  // R1
  always @(posedge clk) begin
    if (!rst_n) reset_quiet_chk: assert (!lock && !resync_req);
  end

  // R2
  word_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_stb && lock) |-> (wgap == wexp - 1));

  // R3
  bit_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && lock) |-> (bgap == bexp - 1));

  // R4
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(w_ok));

  // R4
  lock_tracked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> (w_trk && b_trk));

  // R6
  word_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    w_err |=> !lock);

  // R7
  bit_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b_err |=> !lock);

  // R9
  resync_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((w_err || b_err) && !soft_rst) |=> resync_req);

  // R9
  resync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resync_req && !soft_rst) |=> resync_req);

  // R10
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!lock && !resync_req));
endmodule

bind lockmon lockmon_chk #(
  .WORD_DIV_LO(WORD_DIV_LO), .WORD_DIV_HI(WORD_DIV_HI),
  .FAST_BITS(FAST_BITS), .SLOW_BITS(SLOW_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .ratio_sel(ratio_sel),
  .rate_hi(rate_hi), .lock(lock), .word_stb(word_stb), .bit_stb(bit_stb),
  .resync_req(resync_req), .w_err(w_err), .b_err(b_err), .w_ok(w_ok),
  .w_trk(w_trk), .b_trk(b_trk)
);

// File: tb/lockmon_tb.sv
module lockmon_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0;
  logic ratio_sel = 1'b0;
  logic rate_hi = 1'b1;
  logic wclk_in = 1'b0;
  logic bclk_in = 1'b0;
  logic lock, word_stb, bit_stb, word_err, bit_err, resync_req;

  always #10 clk = ~clk;

  lockmon u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .ratio_sel(ratio_sel),
    .rate_hi(rate_hi), .wclk_in(wclk_in), .bclk_in(bclk_in), .lock(lock),
    .word_stb(word_stb), .bit_stb(bit_stb), .word_err(word_err),
    .bit_err(bit_err), .resync_req(resync_req));

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // generator state
  int cyc = 0, start = 0;
  bit gen_on = 1'b0, wkill = 1'b0;
  int W = 1024, B = 8, ws = 0, wt = 4, bs = 0, bt = 0;
  // observation state
  int wrun = 0, wlast = 0, brun = 0, blast = 0;
  bit saw_werr = 1'b0, saw_berr = 1'b0;

  // fields: ratio_sel, rate_hi, word shift, bit shift, lock expected after
  localparam int VEC [0:9][0:4] = '{
    '{0, 1,  0,  0, 1},
    '{0, 1,  1,  0, 1},
    '{0, 1, -2,  0, 1},
    '{0, 1,  2,  0, 0},
    '{0, 1, -3,  0, 0},
    '{1, 0,  0,  1, 1},
    '{1, 0,  0, -2, 1},
    '{1, 0,  0,  2, 0},
    '{0, 0,  0, -3, 0},
    '{1, 1,  0,  0, 1}
  };

  always @(negedge clk) begin
    int t, ph;
    bit wl, bl;
    cyc++;
    if (!gen_on) begin
      wclk_in <= 1'b0;
      bclk_in <= 1'b0;
    end else begin
      t  = cyc - start;
      ph = t % W;
      wl = ph < W / 2;
      if (ws < 0 && t >= wt * W + ws && t < wt * W) wl = 1'b1;
      if (ws > 0 && t >= wt * W && t < wt * W + ws) wl = 1'b0;
      if (wkill && t >= wt * W - W / 4) wl = 1'b0;
      ph = t % B;
      bl = ph >= B / 2;
      if (bs < 0 && t >= bt * B + bs && t < bt * B) bl = 1'b0;
      if (bs > 0 && t >= bt * B && t < bt * B + bs) bl = 1'b1;
      wclk_in <= wl;
      bclk_in <= bl;
    end
    if (word_stb) begin wlast = wrun; wrun = 1; end else wrun++;
    if (bit_stb)  begin blast = brun; brun = 1; end else brun++;
    if (word_err) saw_werr = 1'b1;
    if (bit_err)  saw_berr = 1'b1;
  end

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic wait_to(input int tt);
    while ((cyc - start) < tt) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic do_reset(input bit r, input bit rt);
    gen_on = 1'b0;
    rst_n = 1'b0;
    ratio_sel = r;
    rate_hi = rt;
    W = r ? 1280 : 1024;
    B = W / (rt ? 128 : 64);
    ws = 0; bs = 0; wt = 4; bt = 4 * W / B + 5; wkill = 1'b0;
    repeat (4) begin @(negedge clk); #1; end
    chk("R1 lock in reset", int'(lock), 0);
    chk("R1 strobes in reset", int'(word_stb | bit_stb | resync_req), 0);
    rst_n = 1'b1;
    repeat (3) begin @(negedge clk); #1; end
    saw_werr = 1'b0;
    saw_berr = 1'b0;
    start = cyc + 1;
    gen_on = 1'b1;
  endtask

  initial begin
    // table of scenarios
    for (int i = 0; i < 10; i++) begin
      string tag;
      do_reset(VEC[i][0][0], VEC[i][1][0]);
      ws = VEC[i][2];
      bs = VEC[i][3];
      wait_to(W + W / 2);
      chk("R4 no lock after one good word", int'(lock), 0);
      wait_to(3 * W + W / 2);
      chk("R4 lock after two good words", int'(lock), 1);
      chk("R2 word strobe spacing", wlast, W);
      chk("R3 bit strobe spacing", blast, B);
      chk("R9 no request without error", int'(resync_req), 0);
      wait_to(5 * W + W / 2);
      if (ws != 0) tag = (VEC[i][4] != 0) ? "R5 word window" : "R6 word window";
      else if (bs != 0) tag = "R7 bit window";
      else tag = "R4 steady lock";
      chk(tag, int'(lock), VEC[i][4]);
      chk("R9 request after error", int'(resync_req), 1 - VEC[i][4]);
      if (VEC[i][4] != 0) chk("R5 R7 no error", int'(saw_werr | saw_berr), 0);
      else if (ws != 0) chk("R6 word_err seen", int'(saw_werr), 1);
      else chk("R7 bit_err seen", int'(saw_berr), 1);
    end

    // error, automatic relock, sticky request, then soft reset
    do_reset(1'b0, 1'b1);
    ws = 2;
    wait_to(5 * W + W / 2);
    chk("R6 lock lost", int'(lock), 0);
    wait_to(8 * W + W / 2);
    chk("R9 relock after error", int'(lock), 1);
    chk("R9 request sticky", int'(resync_req), 1);
    soft_rst = 1'b1;
    @(negedge clk); #1;
    soft_rst = 1'b0;
    @(negedge clk); #1;
    chk("R10 soft reset drops lock", int'(lock), 0);
    chk("R10 soft reset clears request", int'(resync_req), 0);
    wait_to(10 * W + W / 2);
    chk("R10 one word after soft reset", int'(lock), 0);
    wait_to(11 * W + W / 2);
    chk("R10 relock after soft reset", int'(lock), 1);

    // missing word clock
    do_reset(1'b0, 1'b0);
    wkill = 1'b1;
    wait_to(3 * W + W / 2);
    chk("R8 locked before loss", int'(lock), 1);
    wait_to(5 * W + W / 2);
    chk("R8 lock after missing edge", int'(lock), 0);
    chk("R8 word_err seen", int'(saw_werr), 1);

    // reset applied while locked
    do_reset(1'b1, 1'b1);
    wait_to(3 * W + W / 2);
    chk("R1 locked before reset", int'(lock), 1);
    rst_n = 1'b0;
    repeat (2) begin @(negedge clk); #1; end
    chk("R1 reset clears lock", int'(lock), 0);
    chk("R1 reset clears strobes", int'(word_stb | bit_stb | resync_req), 0);
    rst_n = 1'b1;

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 190000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule